// File: doc/BRIEF.md
# Block-Cipher Counter and MAC Mode Sequencer

This block is the software-facing front end of a 128-bit block cipher. Software writes a key, a data block and a counter block as 32-bit words, chooses counter-mode encryption, chained MAC accumulation or both, and then issues a start command. The sequencer sends each block to an external cipher engine through a request/acknowledge port. It XORs the engine output into the proper result and reports completion through a done flag and an optional interrupt line. The cipher rounds live behind the engine port.

The block will not run a cipher operation until a timed self-test has passed. After reset it is in boot mode, where the engine receives a fixed internal key rather than the key written by software. A bypass control removes the engine from the path, so each result collapses to its plain XOR form. The MAC accumulator keeps its value across operations until software clears it, or until software loads a new value into it from the MAC staging words.

Top module: `ccm_seq_ctrl`

## Requirements
- R1: After reset, status reads 0 (done bit 24 and pass bit 25 both low), the mode word (word 21) reads 0 (boot mode, bypass off), irq is low and eng_req is low.
- R2: Word addresses: 0-3 key, 4-7 data, 8-11 counter, 12-15 counter result, 16-19 MAC result, 20 command, 21 mode, 22 status, 23 reserved, 24-27 MAC staging. Word n of a group holds bits 32n+31:32n of its block. The data and counter words read back what was written.
- R3: The key words always read as 0.
- R4: A write of command bit 24 (start) while the mode word has bit 0 (on) and bit 26 (self-test) set begins a self-test. Done rises exactly ST_CYCLES clock edges after the edge that captured the start. Pass (status bit 25) is then 1 if on stayed set throughout.
- R5: Pass reads 0 if on was cleared during the self-test. While pass is 0, a start with self-test clear issues no engine request and leaves done low.
- R6: With mode bit 25 (counter) set, the counter result is E(counter) XOR data, and the engine input is the counter block. Running again with that result as data gives back the original data.
- R7: With mode bit 24 (chained MAC) set, the accumulator becomes E(accumulator XOR data) and the counter block is not used. The accumulator reads at words 16-19.
- R8: Command bit 25 (clear), written together with start, zeroes the accumulator before that operation. Without it, the accumulator carries over from one start to the next.
- R9: With both counter and MAC bits set, one start produces the counter result and the updated accumulator.
- R10: Command bit 26 (load) copies the MAC staging words into the accumulator.
- R11: With mode bit 2 (bypass) set, no engine request is made and the engine is treated as the identity. A counter-only run then sets done one edge after the start edge.
- R12: The engine key is the fixed boot key while mode bit 1 (normal) is 0, and the written key while it is 1.
- R13: An accepted start clears done. On completion, irq rises together with done when mode bit 31 (mask) is 0, and stays low when the mask is 1. Command bit 31 lowers irq.
- R14: A start written while an operation is running is ignored and does not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| eng_req | output | 1 | Engine request, held until acknowledged |
| eng_key | output | 128 | Key presented to the engine |
| eng_in | output | 128 | Block presented to the engine |
| eng_ack | input | 1 | Engine acknowledge, one cycle, with eng_out valid |
| eng_out | input | 128 | Engine output block |
| irq | output | 1 | Completion interrupt |

## Verification
Every result appears a fixed number of edges after the edge that captures the start write. The self-test sets done exactly ST_CYCLES edges later. A bypassed counter-only run sets done one edge later. Irq always changes on the same edge as done. The bench samples on falling edges and checks done low on the edge before its due edge and high on the due edge. Runs that pass through the engine stand-in, whose latency is arbitrary, are checked by polling done within a bounded window, and the result words are read only after done is seen.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
    localparam int WORD_W = 32;
    localparam int NWORDS = 4;
    localparam int BLK_W  = WORD_W * NWORDS;
    localparam int ADDR_W = 5;
    localparam int WSEL_W = $clog2(NWORDS);
    localparam int GRP_W  = ADDR_W - WSEL_W;

    localparam logic [GRP_W-1:0] GRP_KEY    = GRP_W'(0);
    localparam logic [GRP_W-1:0] GRP_DATA   = GRP_W'(1);
    localparam logic [GRP_W-1:0] GRP_CTR    = GRP_W'(2);
    localparam logic [GRP_W-1:0] GRP_CTRRES = GRP_W'(3);
    localparam logic [GRP_W-1:0] GRP_MACRES = GRP_W'(4);
    localparam logic [GRP_W-1:0] GRP_CTL    = GRP_W'(5);
    localparam logic [GRP_W-1:0] GRP_MAC    = GRP_W'(6);

    localparam logic [WSEL_W-1:0] OFS_CMD  = WSEL_W'(0);
    localparam logic [WSEL_W-1:0] OFS_MODE = WSEL_W'(1);
    localparam logic [WSEL_W-1:0] OFS_STAT = WSEL_W'(2);

    // command word bits
    localparam int C_START  = 24;
    localparam int C_CLEAR  = 25;
    localparam int C_LOAD   = 26;
    localparam int C_CLRIRQ = 31;
    // mode word bits
    localparam int M_ON     = 0;
    localparam int M_NORMAL = 1;
    localparam int M_BYPASS = 2;
    localparam int M_MAC    = 24;
    localparam int M_CTR    = 25;
    localparam int M_TEST   = 26;
    localparam int M_MASK   = 31;
    // status word bits
    localparam int S_DONE   = 24;
    localparam int S_PASS   = 25;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_TEST,
        SQ_CTR,
        SQ_MAC
    } seq_e;

    typedef struct packed {
        logic on;
        logic normal;
        logic bypass;
        logic mac;
        logic ctr;
        logic test;
        logic mask;
    } mode_t;

    function automatic mode_t word_to_mode(input logic [WORD_W-1:0] w);
        mode_t m;
        m.on     = w[M_ON];
        m.normal = w[M_NORMAL];
        m.bypass = w[M_BYPASS];
        m.mac    = w[M_MAC];
        m.ctr    = w[M_CTR];
        m.test   = w[M_TEST];
        m.mask   = w[M_MASK];
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] mode_to_word(input mode_t m);
        logic [WORD_W-1:0] w;
        w           = '0;
        w[M_ON]     = m.on;
        w[M_NORMAL] = m.normal;
        w[M_BYPASS] = m.bypass;
        w[M_MAC]    = m.mac;
        w[M_CTR]    = m.ctr;
        w[M_TEST]   = m.test;
        w[M_MASK]   = m.mask;
        return w;
    endfunction
endpackage

// File: rtl/ccm_selftest_timer.sv
module ccm_selftest_timer #(
    parameter int CYCLES = 3330
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic on_i,
    output logic busy_o,
    output logic fin_o,
    output logic ok_o
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    typedef struct packed {
        logic             busy;
        logic             ok;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.busy) begin
            if (!on_i) tmr_d.ok = 1'b0;
            if (tmr_q.cnt == '0) tmr_d.busy = 1'b0;
            else                 tmr_d.cnt  = tmr_q.cnt - 1'b1;
        end else if (start_i) begin
            tmr_d.busy = 1'b1;
            tmr_d.ok   = 1'b1;
            tmr_d.cnt  = CNT_W'(CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy_o = tmr_q.busy;
    assign fin_o  = tmr_q.busy && (tmr_q.cnt == '0);
    assign ok_o   = tmr_q.ok && on_i;

    // R4: the count never leaves the programmed window
    p_cnt_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.busy |-> (int'(tmr_q.cnt) < CYCLES));
    // R4: the run ends on the edge after its final count
    p_fin_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> !busy_o);
endmodule

// File: rtl/ccm_combine.sv
module ccm_combine
    import ccm_pkg::*;
(
    input  logic             bypass_i,
    input  logic [BLK_W-1:0] eng_in_i,
    input  logic [BLK_W-1:0] eng_out_i,
    input  logic [BLK_W-1:0] mix_i,
    output logic [BLK_W-1:0] res_o
);
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [WORD_W-1:0] sel;
        assign sel = bypass_i ? eng_in_i[w*WORD_W +: WORD_W]
                              : eng_out_i[w*WORD_W +: WORD_W];
        assign res_o[w*WORD_W +: WORD_W] = sel ^ mix_i[w*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/ccm_seq_ctrl.sv
module ccm_seq_ctrl
    import ccm_pkg::*;
#(
    parameter int               ST_CYCLES = 3330,
    parameter logic [BLK_W-1:0] BOOT_KEY  = 128'h5a5a_0f0f_c3c3_9696_a5a5_f0f0_3c3c_6969
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              eng_req,
    output logic [BLK_W-1:0]  eng_key,
    output logic [BLK_W-1:0]  eng_in,
    input  logic              eng_ack,
    input  logic [BLK_W-1:0]  eng_out,
    output logic              irq
);
    typedef struct packed {
        seq_e             st;
        mode_t            mode;
        logic [BLK_W-1:0] key;
        logic [BLK_W-1:0] data;
        logic [BLK_W-1:0] ctr;
        logic [BLK_W-1:0] ctr_res;
        logic [BLK_W-1:0] acc;
        logic [BLK_W-1:0] mac_stage;
        logic             done;
        logic             pass;
        logic             irq;
    } regs_t;

    regs_t r_d, r_q;

    logic [GRP_W-1:0]  grp;
    logic [WSEL_W-1:0] ofs;
    logic              cmd_wr, cmd_start, cmd_clear, cmd_load, cmd_clrirq;
    logic              st_go, st_busy, st_fin, st_ok;
    logic              in_op, step;
    logic [BLK_W-1:0]  mix, res;

    assign grp        = bus_addr[ADDR_W-1:WSEL_W];
    assign ofs        = bus_addr[WSEL_W-1:0];
    assign cmd_wr     = bus_wr && (grp == GRP_CTL) && (ofs == OFS_CMD);
    assign cmd_start  = cmd_wr && bus_wdata[C_START];
    assign cmd_clear  = cmd_wr && bus_wdata[C_CLEAR];
    assign cmd_load   = cmd_wr && bus_wdata[C_LOAD];
    assign cmd_clrirq = cmd_wr && bus_wdata[C_CLRIRQ];

    assign st_go = (r_q.st == SQ_IDLE) && cmd_start && r_q.mode.on && r_q.mode.test;

    ccm_selftest_timer #(.CYCLES(ST_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (st_go),
        .on_i    (r_q.mode.on),
        .busy_o  (st_busy),
        .fin_o   (st_fin),
        .ok_o    (st_ok)
    );

    // engine side
    assign in_op   = (r_q.st == SQ_CTR) || (r_q.st == SQ_MAC);
    assign eng_req = in_op && !r_q.mode.bypass;
    assign eng_key = r_q.mode.normal ? r_q.key : BOOT_KEY;
    assign eng_in  = (r_q.st == SQ_CTR) ? r_q.ctr : (r_q.acc ^ r_q.data);
    assign step    = in_op && (r_q.mode.bypass || eng_ack);
    assign mix     = (r_q.st == SQ_CTR) ? r_q.data : '0;

    ccm_combine u_combine (
        .bypass_i  (r_q.mode.bypass),
        .eng_in_i  (eng_in),
        .eng_out_i (eng_out),
        .mix_i     (mix),
        .res_o     (res)
    );

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            unique case (grp)
                GRP_KEY:  r_d.key[int'(ofs)*WORD_W +: WORD_W]       = bus_wdata;
                GRP_DATA: r_d.data[int'(ofs)*WORD_W +: WORD_W]      = bus_wdata;
                GRP_CTR:  r_d.ctr[int'(ofs)*WORD_W +: WORD_W]       = bus_wdata;
                GRP_MAC:  r_d.mac_stage[int'(ofs)*WORD_W +: WORD_W] = bus_wdata;
                GRP_CTL:  if (ofs == OFS_MODE) r_d.mode = word_to_mode(bus_wdata);
                default: ;
            endcase
        end
        if (cmd_clrirq) r_d.irq = 1'b0;

        unique case (r_q.st)
            SQ_IDLE: begin
                if (cmd_load)  r_d.acc = r_q.mac_stage;
                if (cmd_clear) r_d.acc = '0;
                if (st_go) begin
                    r_d.done = 1'b0;
                    r_d.st   = SQ_TEST;
                end else if (cmd_start && r_q.mode.on && !r_q.mode.test && r_q.pass
                             && (r_q.mode.ctr || r_q.mode.mac)) begin
                    r_d.done = 1'b0;
                    r_d.st   = r_q.mode.ctr ? SQ_CTR : SQ_MAC;
                end
            end
            SQ_TEST: begin
                if (st_fin) begin
                    r_d.pass = st_ok;
                    r_d.done = 1'b1;
                    if (!r_q.mode.mask) r_d.irq = 1'b1;
                    r_d.st   = SQ_IDLE;
                end
            end
            SQ_CTR: begin
                if (step) begin
                    r_d.ctr_res = res;
                    if (r_q.mode.mac) begin
                        r_d.st = SQ_MAC;
                    end else begin
                        r_d.done = 1'b1;
                        if (!r_q.mode.mask) r_d.irq = 1'b1;
                        r_d.st   = SQ_IDLE;
                    end
                end
            end
            SQ_MAC: begin
                if (step) begin
                    r_d.acc  = res;
                    r_d.done = 1'b1;
                    if (!r_q.mode.mask) r_d.irq = 1'b1;
                    r_d.st   = SQ_IDLE;
                end
            end
            default: r_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= SQ_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (grp)
            GRP_DATA:   bus_rdata = r_q.data[int'(ofs)*WORD_W +: WORD_W];
            GRP_CTR:    bus_rdata = r_q.ctr[int'(ofs)*WORD_W +: WORD_W];
            GRP_CTRRES: bus_rdata = r_q.ctr_res[int'(ofs)*WORD_W +: WORD_W];
            GRP_MACRES: bus_rdata = r_q.acc[int'(ofs)*WORD_W +: WORD_W];
            GRP_MAC:    bus_rdata = r_q.mac_stage[int'(ofs)*WORD_W +: WORD_W];
            GRP_CTL: begin
                if (ofs == OFS_MODE) bus_rdata = mode_to_word(r_q.mode);
                if (ofs == OFS_STAT) begin
                    bus_rdata[S_DONE] = r_q.done;
                    bus_rdata[S_PASS] = r_q.pass;
                end
            end
            default: bus_rdata = '0;
        endcase
    end

    assign irq = r_q.irq;

    // R6: a request is held until the engine acknowledges it
    p_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_ack) |=> eng_req);
    // R5: no engine traffic before a passed self-test
    p_req_needs_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> r_q.pass);
    // R4: the sequencer is idle whenever done is set, and not in the timer
    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> ((r_q.st == SQ_IDLE) && !st_busy));
    // R13: irq only rises when the mask was clear
    p_irq_masked_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !$past(r_q.mode.mask));
    // R3: key words never read back
    p_key_hidden_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grp == GRP_KEY) |-> (bus_rdata == '0));
endmodule

// File: tb/ccm_seq_ctrl_tb_top.sv
module ccm_seq_ctrl_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          ST_N       = 3330;
    localparam logic [127:0] BOOTK     = 128'h0bad_cafe_1357_9bdf_2468_ace0_feed_f00d;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [4:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         eng_req;
    logic [127:0] eng_key, eng_in;
    logic         eng_ack;
    logic [127:0] eng_out;
    logic         irq;

    int checks = 0;
    int fails  = 0;
    int req_cnt;
    int lat;
    logic [127:0] last_key, last_in;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccm_seq_ctrl #(.ST_CYCLES(ST_N), .BOOT_KEY(BOOTK)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_req(eng_req),
        .eng_key(eng_key), .eng_in(eng_in), .eng_ack(eng_ack),
        .eng_out(eng_out), .irq(irq)
    );

    function automatic logic [127:0] cipher(input logic [127:0] x, input logic [127:0] k);
        return {x[95:0], x[127:96]} ^ k;
    endfunction

    // engine stand-in: acknowledges three cycles into a request
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_ack <= 1'b0; lat <= 0; eng_out <= '0; req_cnt <= 0;
            last_key <= '0; last_in <= '0;
        end else begin
            if (eng_req) req_cnt <= req_cnt + 1;
            if (eng_ack) begin
                eng_ack <= 1'b0; lat <= 0;
            end else if (eng_req) begin
                if (lat == 2) begin
                    eng_ack  <= 1'b1;
                    eng_out  <= cipher(eng_in, eng_key);
                    last_key <= eng_key;
                    last_in  <= eng_in;
                end else begin
                    lat <= lat + 1;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
        $finish;
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 5'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic wr_blk(input int g, input logic [127:0] v);
        for (int w = 0; w < 4; w++) wr(g*4 + w, v[w*32 +: 32]);
    endtask

    task automatic rd_blk(input int g, output logic [127:0] v);
        logic [31:0] t;
        for (int w = 0; w < 4; w++) begin
            rd(g*4 + w, t);
            v[w*32 +: 32] = t;
        end
    endtask

    function automatic logic [31:0] mode(input bit on, input bit nrm, input bit byp,
                                         input bit mac, input bit ctr, input bit tst, input bit msk);
        logic [31:0] w = '0;
        w[0] = on; w[1] = nrm; w[2] = byp; w[24] = mac; w[25] = ctr; w[26] = tst; w[31] = msk;
        return w;
    endfunction

    localparam logic [31:0] START = 32'h0100_0000;
    localparam logic [31:0] CLEAR = 32'h0200_0000;
    localparam logic [31:0] LOAD  = 32'h0400_0000;
    localparam logic [31:0] CLIRQ = 32'h8000_0000;

    task automatic status(output logic done, output logic pass);
        logic [31:0] s;
        rd(22, s);
        done = s[24]; pass = s[25];
    endtask

    task automatic wait_done(input string tag, input int maxc);
        logic d, p;
        int n = 0;
        status(d, p);
        while (!d && n < maxc) begin
            @(negedge clk); n++;
            status(d, p);
        end
        chk(tag, 128'(d), 128'd1);
    endtask

    localparam logic [127:0] KEY = 128'h0011_2233_4455_6677_8899_aabb_ccdd_eeff;
    localparam logic [127:0] DAT = 128'h0123_4567_face_face_beef_beef_dead_dead;
    localparam logic [127:0] CTR = 128'h0000_0000_1111_1111_2222_2222_3333_3333;

    task automatic t_reset;
        logic [31:0] w; logic d, p;
        status(d, p);
        chk("R1 done", 128'(d), 0);
        chk("R1 pass", 128'(p), 0);
        rd(21, w);
        chk("R1 mode word", 128'(w), 0);
        chk("R1 irq/req", {126'd0, irq, eng_req}, 0);
    endtask

    task automatic t_before_pass;
        int r0; logic d, p; logic [127:0] v;
        wr(21, mode(1, 1, 0, 0, 1, 0, 0));
        wr_blk(1, DAT);
        wr_blk(2, CTR);
        rd_blk(1, v); chk("R2 data readback", v, DAT);
        rd_blk(2, v); chk("R2 counter readback", v, CTR);
        r0 = req_cnt;
        wr(20, START);
        repeat (20) @(negedge clk);
        status(d, p);
        chk("R5 start ignored before pass: done", 128'(d), 0);
        chk("R5 no engine request before pass", 128'(req_cnt - r0), 0);
    endtask

    task automatic t_test_fail;
        logic d, p;
        wr(21, mode(1, 0, 0, 0, 0, 1, 0));
        wr(20, START);
        repeat (50) @(negedge clk);
        wr(21, mode(0, 0, 0, 0, 0, 1, 0));
        wait_done("R5 failing self-test completes", ST_N + 10);
        status(d, p);
        chk("R5 pass low after on dropped", 128'(p), 0);
        chk("R13 irq after self-test", 128'(irq), 1);
        wr(20, CLIRQ);
        chk("R13 clear-irq lowers irq", 128'(irq), 0);
    endtask

    task automatic t_test_pass;
        logic d, p;
        wr(21, mode(1, 0, 0, 0, 0, 1, 0));
        wr(20, START);
        status(d, p);
        chk("R13 accepted start clears done", 128'(d), 0);
        repeat (100) @(negedge clk);
        wr(20, START);
        repeat (ST_N - 103) @(negedge clk);
        status(d, p);
        chk("R14 done not early (restart ignored)", 128'(d), 0);
        @(negedge clk);
        status(d, p);
        chk("R4 done on due edge", 128'(d), 1);
        chk("R4 pass set", 128'(p), 1);
        chk("R13 irq with done", 128'(irq), 1);
        wr(20, CLIRQ);
    endtask

    task automatic t_ctr;
        logic [127:0] r, exp;
        logic [31:0] w;
        wr(21, mode(1, 1, 0, 0, 1, 0, 1));
        wr_blk(0, KEY);
        for (int i = 0; i < 4; i++) begin
            rd(i, w); chk("R3 key word reads zero", 128'(w), 0);
        end
        wr_blk(1, DAT);
        wr_blk(2, CTR);
        wr(20, START);
        wait_done("R6 counter run done", 100);
        exp = cipher(CTR, KEY) ^ DAT;
        rd_blk(3, r);
        chk("R6 counter result", r, exp);
        chk("R6 engine input is counter", last_in, CTR);
        chk("R12 normal mode uses written key", last_key, KEY);
        chk("R13 masked completion leaves irq low", 128'(irq), 0);
        wr_blk(1, r);
        wr(20, START);
        wait_done("R6 decrypt done", 100);
        rd_blk(3, r);
        chk("R6 round trip restores data", r, DAT);
    endtask

    task automatic t_mac;
        logic [127:0] r, a1;
        wr(21, mode(1, 1, 0, 1, 0, 0, 1));
        wr_blk(1, DAT);
        wr_blk(2, 128'hffff_eeee_dddd_cccc_bbbb_aaaa_9999_8888);
        wr(20, START | CLEAR);
        wait_done("R7 mac run done", 100);
        a1 = cipher(DAT, KEY);
        rd_blk(4, r);
        chk("R8 clear then R7 mac result", r, a1);
        wr(20, START);
        wait_done("R8 second mac run done", 100);
        rd_blk(4, r);
        chk("R8 accumulator carries over", r, cipher(a1 ^ DAT, KEY));
    endtask

    task automatic t_both;
        logic [127:0] r;
        wr(21, mode(1, 1, 0, 1, 1, 0, 1));
        wr_blk(1, DAT);
        wr_blk(2, CTR);
        wr(20, START | CLEAR);
        wait_done("R9 combined run done", 200);
        rd_blk(3, r);
        chk("R9 counter result", r, cipher(CTR, KEY) ^ DAT);
        rd_blk(4, r);
        chk("R9 mac result", r, cipher(DAT, KEY));
    endtask

    task automatic t_load;
        logic [127:0] r, m;
        m = 128'h1234_5678_9abc_def0_0fed_cba9_8765_4321;
        wr(21, mode(1, 1, 0, 1, 0, 0, 1));
        wr_blk(6, m);
        wr(20, LOAD);
        rd_blk(4, r);
        chk("R10 load copies staging words", r, m);
        wr(20, START);
        wait_done("R10 run after load done", 100);
        rd_blk(4, r);
        chk("R10 mac from loaded value", r, cipher(m ^ DAT, KEY));
    endtask

    task automatic t_bypass;
        logic [127:0] r; logic d, p; int r0;
        wr(21, mode(1, 1, 1, 0, 1, 0, 1));
        r0 = req_cnt;
        wr(20, START);
        status(d, p);
        chk("R11 done low on start edge", 128'(d), 0);
        @(negedge clk);
        status(d, p);
        chk("R11 done one edge later", 128'(d), 1);
        rd_blk(3, r);
        chk("R11 bypass result is plain xor", r, CTR ^ DAT);
        chk("R11 no engine request", 128'(req_cnt - r0), 0);
    endtask

    task automatic t_boot;
        logic [127:0] r;
        wr(21, mode(1, 0, 0, 0, 1, 0, 1));
        wr(20, START);
        wait_done("R12 boot run done", 100);
        rd_blk(3, r);
        chk("R12 boot key result", r, cipher(CTR, BOOTK) ^ DAT);
        chk("R12 engine sees boot key", last_key, BOOTK);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_before_pass();
        t_test_fail();
        t_test_pass();
        t_ctr();
        t_mac();
        t_both();
        t_load();
        t_bypass();
        t_boot();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule